// File: doc/BRIEF.md
# Bit-Vector Buddy Allocator

This block manages one page of heap whose state is a vector with one bit per fixed-size memory block. A set bit marks an allocated block. A request gives an object length in blocks. The block rounds that length up to the next power of two. It then searches the vector for the lowest free chunk of that size that is aligned to its own size, as in a buddy tree. Only the requested number of blocks is marked allocated. The rest of the chunk stays free and can be used by later requests.

The chunk search is combinational. Its result is registered in two steps. On the clock edge that samples the request, the allocation vector, the returned block offset and the fail flag are latched. On the next edge, the boundary vector records the object's last block, and a completion pulse is raised. The block also reports the largest aligned free chunk that is still left in the vector, so that a surrounding unit can decide whether this page can serve a request at all.

Top module: `buddy_bitvec_alloc`

## Requirements
- R1: After reset, `alloc_vec` and `size_vec` are all zero, `done`, `fail` and `obj_off` are zero, and `largest_free` equals the vector length `NBLK`.
- R2: A request of n blocks selects the chunk size 2^ceil(log2 n). Chunk j of size c covers blocks j*c to j*c+c-1, and `alloc_vec` bit b stands for block b. The first chunk, in order of increasing offset, whose blocks are all free is chosen. `obj_off` returns its first block index.
- R3: Exactly the n blocks from `obj_off` to `obj_off`+n-1 are set in `alloc_vec`. The unused tail of the chunk and every other bit keep their values.
- R4: `alloc_vec`, `obj_off` and `fail` take their new values on the edge that samples `req_valid`. `size_vec` changes, and `done` is high for one cycle, after the following edge.
- R5: On success, `size_vec` bit `obj_off`+n-1 (the object's last block) is set. No other bit of `size_vec` changes.
- R6: `largest_free` is the size of the largest aligned, fully free power-of-two chunk in `alloc_vec`, or 0 when no block is free. It reflects a new allocation from the cycle after the request edge.
- R7: When no free chunk of the rounded size exists, `fail` is 1, `obj_off` is 0, and both vectors are left unchanged.
- R8: A request of size 0, or of more than `NBLK` blocks, fails as in R7.
- R9: A request presented in the cycle right after an accepted request (while that request finishes its second step) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Allocation request strobe |
| req_size | input | $clog2(NBLK)+1 | Requested length in blocks |
| done | output | 1 | One-cycle pulse when a request has completed |
| fail | output | 1 | Last request could not be served |
| obj_off | output | $clog2(NBLK) | Block offset of the last allocated object |
| alloc_vec | output | NBLK | Allocation status, bit b for block b |
| size_vec | output | NBLK | Object end markers, bit set on each object's last block |
| largest_free | output | $clog2(NBLK)+1 | Largest aligned free chunk size in blocks |

## Verification
A wrong choice of level or of chunk shows at the ports on the edge that samples the request. It appears as an `obj_off` that is not the lowest fitting aligned offset, or as `alloc_vec` bits set outside the requested run. A wrong end marker can only be seen one edge later in `size_vec`. A wrong free-space summary shows in `largest_free` from the cycle after the request. The bench walks one fill sequence that reaches each chunk level, every failure cause and a full page. After every step it compares all outputs against values worked out by hand. Directed cases then probe the two-step timing, the ignored back-to-back request and a reset taken from a full page.

// File: rtl/bva_pkg.sv
// Package: shared helpers for the bit-vector buddy allocator.
// Assumes: callers pass a positive block count.
package bva_pkg;
    // Smallest k with 2^k >= n (0 for n <= 1).
    function automatic int ceil_lg(input int n);
        int r;
        r = 0;
        for (int k = 0; k < 31; k++) begin
            if ((1 << k) < n) r = k + 1;
        end
        return r;
    endfunction
endpackage

// File: rtl/bva_chunk_scan.sv
// Module: marks, for every buddy level, which aligned chunks are entirely free.
// Assumes: N is a power of two; bits of level k above N>>k are tied to zero.
module bva_chunk_scan #(
    parameter int N  = 16,
    localparam int LW = $clog2(N),
    localparam int LV = LW + 1
) (
    input  logic [N-1:0]          alloc,
    output logic [LV-1:0][N-1:0]  free_map,
    output logic [LV-1:0]         any_free
);
    // One OR-reduction per aligned chunk at each level.
    for (genvar k = 0; k < LV; k++) begin : g_lvl
        localparam int CS = 1 << k;
        localparam int NC = N >> k;
        for (genvar j = 0; j < N; j++) begin : g_chunk
            if (j < NC) begin : g_real
                assign free_map[k][j] = ~|alloc[j*CS +: CS];
            end else begin : g_pad
                assign free_map[k][j] = 1'b0;
            end
        end
        assign any_free[k] = |free_map[k];
    end
endmodule

// File: rtl/bva_first_pick.sv
// Module: lowest-index priority pick over a candidate mask.
// Assumes: idx is meaningful only while found is high.
module bva_first_pick #(
    parameter int N  = 16,
    localparam int LW = $clog2(N)
) (
    input  logic [N-1:0]  mask,
    output logic          found,
    output logic [LW-1:0] idx
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) begin
                found = 1'b1;
                idx   = LW'(i);
            end
        end
    end

    // R2: the picked bit is set and no lower bit is set
    always_comb begin
        pick_lowest_chk: assert (!found ||
            (mask[idx] && ((mask & ((N'(1) << idx) - N'(1))) == '0)));
    end
endmodule

// File: rtl/buddy_bitvec_alloc.sv
// Module: buddy-sized first-fit allocator over one page bit-vector.
// Step one latches the new allocation vector, offset and fail flag.
// Step two latches the object end marker and pulses done.
// Assumes: NBLK is a power of two; a request is held off while step two runs.
module buddy_bitvec_alloc #(
    parameter int NBLK = 16,
    localparam int LW  = $clog2(NBLK),
    localparam int SW  = LW + 1,
    localparam int LV  = LW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [SW-1:0]   req_size,
    output logic            done,
    output logic            fail,
    output logic [LW-1:0]   obj_off,
    output logic [NBLK-1:0] alloc_vec,
    output logic [NBLK-1:0] size_vec,
    output logic [SW-1:0]   largest_free
);
    import bva_pkg::*;

    logic [LV-1:0][NBLK-1:0] free_map;
    logic [LV-1:0]           any_free;
    logic [NBLK-1:0]         sel_mask;
    logic                    pick_found;
    logic [LW-1:0]           pick_idx;
    logic                    bad_size;
    logic                    fit_ok;
    logic                    accept;
    int                      req_lvl;
    int                      off_i;
    logic [NBLK-1:0]         mark;
    logic                    st_valid;
    logic                    st_ok;
    logic [LW-1:0]           st_off;
    logic [SW-1:0]           st_n;
    logic [SW-1:0]           last_sum;
    logic [LW-1:0]           last_blk;

    bva_chunk_scan #(.N(NBLK)) u_scan (
        .alloc    (alloc_vec),
        .free_map (free_map),
        .any_free (any_free)
    );

    bva_first_pick #(.N(NBLK)) u_pick (
        .mask  (sel_mask),
        .found (pick_found),
        .idx   (pick_idx)
    );

    // Validate the size and choose the candidate chunks of the rounded level.
    always_comb begin
        bad_size = (req_size == '0) || (req_size > SW'(NBLK));
        req_lvl  = ceil_lg(int'(req_size));
        sel_mask = '0;
        for (int k = 0; k < LV; k++) begin
            if (!bad_size && k == req_lvl) sel_mask = free_map[k];
        end
    end

    // Form the object offset and the run of exactly req_size blocks to mark.
    always_comb begin
        off_i  = int'(pick_idx) << req_lvl;
        fit_ok = !bad_size && pick_found;
        accept = req_valid && !st_valid;
        for (int b = 0; b < NBLK; b++) begin
            mark[b] = (b >= off_i) && (b < off_i + int'(req_size));
        end
    end

    // Step one: latch allocation vector, result and stage-two context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alloc_vec <= '0;
            obj_off   <= '0;
            fail      <= 1'b0;
            st_valid  <= 1'b0;
            st_ok     <= 1'b0;
            st_off    <= '0;
            st_n      <= '0;
        end else begin
            st_valid <= accept;
            if (accept) begin
                fail    <= !fit_ok;
                obj_off <= fit_ok ? LW'(off_i) : '0;
                st_ok   <= fit_ok;
                st_off  <= LW'(off_i);
                st_n    <= req_size;
                if (fit_ok) alloc_vec <= alloc_vec | mark;
            end
        end
    end

    // Last block of the object just placed.
    always_comb begin
        last_sum = {1'b0, st_off} + st_n - SW'(1);
        last_blk = last_sum[LW-1:0];
    end

    // Step two: record the object end marker and signal completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_vec <= '0;
            done     <= 1'b0;
        end else begin
            done <= st_valid;
            if (st_valid && st_ok) size_vec <= size_vec | (NBLK'(1) << last_blk);
        end
    end

    // Largest aligned fully free chunk of the current vector.
    always_comb begin
        largest_free = '0;
        for (int k = 0; k < LV; k++) begin
            if (any_free[k]) largest_free = SW'(1) << k;
        end
    end

    // R3: allocated blocks never return to free
    alloc_grow_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> ((alloc_vec & $past(alloc_vec)) == $past(alloc_vec)));

    // R7: a failed request leaves the allocation vector as it was
    fail_keeps_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ok) |-> (alloc_vec == $past(alloc_vec)));

    // R9: no request is accepted while step two is pending
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |=> !st_valid);

    // R5: every end marker sits on an allocated block
    marker_in_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size_vec & ~alloc_vec) == '0);

    // R4: completion pulses last a single cycle
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/test_buddy_bitvec_alloc.sv
module test_buddy_bitvec_alloc;
    localparam int NBLK = 16;
    localparam int LW   = $clog2(NBLK);
    localparam int SW   = LW + 1;
    localparam int NV   = 10;

    // Fill sequence from reset: size, fail, offset, alloc, size_vec, largest.
    localparam int VSZ [NV] = '{5, 3, 1, 2, 8, 4, 0, 17, 1, 1};
    localparam int VFL [NV] = '{0, 0, 0, 0, 1, 0, 1, 1, 0, 1};
    localparam int VOF [NV] = '{0, 8, 5, 6, 0, 12, 0, 0, 11, 0};
    localparam int VAV [NV] = '{'h001F, 'h071F, 'h073F, 'h07FF, 'h07FF,
                                'hF7FF, 'hF7FF, 'hF7FF, 'hFFFF, 'hFFFF};
    localparam int VSV [NV] = '{'h0010, 'h0410, 'h0430, 'h04B0, 'h04B0,
                                'h84B0, 'h84B0, 'h84B0, 'h8CB0, 'h8CB0};
    localparam int VLG [NV] = '{8, 4, 4, 4, 4, 1, 1, 1, 0, 0};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [SW-1:0]   req_size = '0;
    logic            done;
    logic            fail;
    logic [LW-1:0]   obj_off;
    logic [NBLK-1:0] alloc_vec;
    logic [NBLK-1:0] size_vec;
    logic [SW-1:0]   largest_free;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    buddy_bitvec_alloc #(.NBLK(NBLK)) i_buddy_bitvec_alloc (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
        .done(done), .fail(fail), .obj_off(obj_off), .alloc_vec(alloc_vec),
        .size_vec(size_vec), .largest_free(largest_free)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Present one request; returns at the negedge after the second step.
    task automatic do_req(input int n);
        @(negedge clk);
        req_valid = 1'b1;
        req_size  = SW'(n);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk("R1 alloc_vec", int'(alloc_vec), 0);
        chk("R1 size_vec", int'(size_vec), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 fail", int'(fail), 0);
        chk("R1 obj_off", int'(obj_off), 0);
        chk("R1 largest_free", int'(largest_free), NBLK);

        // R2 R3 R5 R6 R7 R8 vector walk
        for (int i = 0; i < NV; i++) begin
            do_req(VSZ[i]);
            chk($sformatf("R4 done row %0d", i), int'(done), 1);
            chk($sformatf("R7 R8 fail row %0d", i), int'(fail), VFL[i]);
            chk($sformatf("R2 obj_off row %0d", i), int'(obj_off), VOF[i]);
            chk($sformatf("R3 alloc_vec row %0d", i), int'(alloc_vec), VAV[i]);
            chk($sformatf("R5 size_vec row %0d", i), int'(size_vec), VSV[i]);
            chk($sformatf("R6 largest_free row %0d", i), int'(largest_free), VLG[i]);
        end

        // R1 reset from a full page
        do_reset();
        @(negedge clk);
        chk("R1 alloc after full", int'(alloc_vec), 0);
        chk("R1 largest after full", int'(largest_free), NBLK);

        // R4 two-step timing, with R9 request held for a second cycle
        @(negedge clk);
        req_valid = 1'b1;
        req_size  = SW'(2);
        @(negedge clk);
        chk("R4 alloc after first edge", int'(alloc_vec), 'h0003);
        chk("R4 size_vec not yet", int'(size_vec), 0);
        chk("R4 done not yet", int'(done), 0);
        chk("R6 largest after first edge", int'(largest_free), 8);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R4 done after second edge", int'(done), 1);
        chk("R5 size_vec after second edge", int'(size_vec), 'h0002);
        chk("R9 held request ignored", int'(alloc_vec), 'h0003);
        @(negedge clk);
        chk("R4 done one cycle", int'(done), 0);
        chk("R9 alloc still", int'(alloc_vec), 'h0003);

        // R2 alignment: size 3 skips the partly used 4-chunk at 0
        do_req(3);
        chk("R2 aligned offset", int'(obj_off), 4);
        chk("R3 tail left free", int'(alloc_vec), 'h0073);
        chk("R5 end marker", int'(size_vec), 'h0042);
        // R2 size 2 uses the free pair right after the first object
        do_req(2);
        chk("R2 reuse gap", int'(obj_off), 2);
        chk("R3 gap filled", int'(alloc_vec), 'h007F);

        finish_run();
    end
endmodule